// File: doc/BRIEF.md
# Serial NOR Flash Device Emulator

This block behaves as a small serial NOR flash on a mode-0 SPI bus, so that a host SPI controller can be exercised against real flash rules without a physical part. The serial pins are oversampled on a fast system clock. Each completed byte is handed to a command decoder that runs the status, identification, read, page-program and sector-erase commands against an array of on-chip storage whose size is a parameter.

The emulator applies flash rules in hardware. Programming can only clear bits. Erase works on whole 4 KB sectors and fills them with 0xFF. Page data is collected in a 256-byte staging buffer whose index wraps inside the page, and it is written to the array only after chip select is released. While a program or erase runs, a timed busy window holds, WEL clears itself when the job ends, and every command except the status read is dropped. When the host deselects the device, the data-out pin floats so that other devices can share the line.

Top module: `nor_flash_emu`

## Requirements
- R1: While `spi_ss_n` is high, `spi_miso` is high-impedance. Bytes move MSB first in SPI mode 0: MOSI is sampled on the rising SCK edge and MISO changes after the falling edge.
- R2: Opcode 0x9F returns the manufacturer byte `MFR_ID`, then `DEV_ID[15:8]`, then `DEV_ID[7:0]`.
- R3: Opcode 0x05 returns the status byte {6'b0, WEL, BUSY}, with BUSY in bit 0 and WEL in bit 1. The byte is sent again on every further 8 clocks until deselect, and the command is accepted even while BUSY is 1.
- R4: WEL is 0 after reset. Opcode 0x06 sets it and opcode 0x04 clears it.
- R5: Page program (0x02) and sector erase (0x20) received while WEL is 0 are ignored: the array does not change and BUSY stays 0.
- R6: Read (0x03) takes a 24-bit address, MSB first, and returns consecutive bytes with no page limit. It needs no WEL and never sets BUSY.
- R7: A programmed byte becomes the old stored value ANDed with the new byte.
- R8: Program data wraps from byte 0xFF of a page to byte 0x00 of the same page.
- R9: Sector erase writes 0xFF to every byte of the 4 KB sector that holds the address and leaves every other sector unchanged.
- R10: BUSY rises when chip select is released after a valid program or erase and stays 1 for `PROG_CYCLES` or `ERASE_CYCLES` clocks. When it falls, WEL is 0.
- R11: While BUSY is 1, every opcode except 0x05 is ignored, and MISO returns 0xFF for the whole transaction.
- R12: A byte cut short by deselect is discarded, so the next transaction starts aligned. A program ended before one full data byte commits nothing and does not set BUSY.
- R13: After reset, every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_ss_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host; high-impedance when deselected |

## Verification
On every cycle, the embedded assertions check these rules:
- a program or erase job starts only with WEL set, and WEL is clear when the job ends;
- the staging buffer is never written while busy;
- array writes happen only inside the busy window;
- a program write never sets a bit, and an erase write leaves 0xFF.

Only the bench scenarios can show the following:
- how bytes are framed on the pins;
- the identification order;
- page wrap, and reads that run across a page boundary;
- sector isolation;
- that commands sent during BUSY are dropped;
- that partial bytes and truncated programs leave no trace.

// File: rtl/nfe_pkg.sv
package nfe_pkg;
    localparam int ADDR_W       = 24;
    localparam int PAGE_AW      = 8;
    localparam int SECTOR_AW    = 12;
    localparam int PAGE_BYTES   = 1 << PAGE_AW;
    localparam int SECTOR_BYTES = 1 << SECTOR_AW;
    localparam int WALK_W       = SECTOR_AW + 1;

    localparam logic [7:0] CMD_WR_ENABLE  = 8'h06;
    localparam logic [7:0] CMD_WR_DISABLE = 8'h04;
    localparam logic [7:0] CMD_STATUS     = 8'h05;
    localparam logic [7:0] CMD_PROGRAM    = 8'h02;
    localparam logic [7:0] CMD_ERASE4K    = 8'h20;
    localparam logic [7:0] CMD_IDENT      = 8'h9F;
    localparam logic [7:0] CMD_READ       = 8'h03;
    localparam logic [7:0] IDLE_BYTE      = 8'hFF;

    typedef enum logic [3:0] {
        PH_IDLE, PH_OPCODE, PH_ADDR, PH_RDATA, PH_PDATA,
        PH_ARMED, PH_STATUS, PH_IDENT, PH_SKIP
    } phase_t;

    typedef enum logic [1:0] {K_READ, K_PROG, K_ERASE} kind_t;
    typedef enum logic [1:0] {JOB_NONE, JOB_PROG, JOB_ERASE} job_t;
endpackage

// File: rtl/nfe_spi_link.sv
module nfe_spi_link
    import nfe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ss_n_i,
    input  logic       sck_i,
    input  logic       mosi_i,
    input  logic [7:0] tx_next_i,
    output logic       sel_o,
    output logic       ss_fall_o,
    output logic       ss_rise_o,
    output logic       byte_valid_o,
    output logic [7:0] rx_byte_o,
    output logic       tx_bit_o
);
    typedef struct packed {
        logic [1:0] ss_s;
        logic [1:0] sck_s;
        logic [1:0] mosi_s;
        logic       ss_prev;
        logic       sck_prev;
        logic [2:0] bit_cnt;
        logic [7:0] rx_sh;
        logic [7:0] tx_sh;
        logic       vld;
        logic [7:0] rx_byte;
    } link_t;

    link_t q, d;
    logic  sck_rise, sck_fall;

    assign sel_o        = !q.ss_s[1];
    assign ss_fall_o    = q.ss_prev && !q.ss_s[1];
    assign ss_rise_o    = !q.ss_prev && q.ss_s[1];
    assign sck_rise     = !q.sck_prev && q.sck_s[1];
    assign sck_fall     = q.sck_prev && !q.sck_s[1];
    assign byte_valid_o = q.vld;
    assign rx_byte_o    = q.rx_byte;
    assign tx_bit_o     = q.tx_sh[7];

    always_comb begin
        d          = q;
        d.ss_s     = {q.ss_s[0], ss_n_i};
        d.sck_s    = {q.sck_s[0], sck_i};
        d.mosi_s   = {q.mosi_s[0], mosi_i};
        d.ss_prev  = q.ss_s[1];
        d.sck_prev = q.sck_s[1];
        d.vld      = 1'b0;
        if (ss_fall_o) begin
            d.bit_cnt = '0;
            d.tx_sh   = tx_next_i;
        end else if (!sel_o) begin
            d.bit_cnt = '0;
        end else if (sck_rise) begin
            d.rx_sh   = {q.rx_sh[6:0], q.mosi_s[1]};
            d.bit_cnt = q.bit_cnt + 3'd1;
            if (q.bit_cnt == 3'd7) begin
                d.vld     = 1'b1;
                d.rx_byte = {q.rx_sh[6:0], q.mosi_s[1]};
            end
        end else if (sck_fall) begin
            if (q.bit_cnt == 3'd0) d.tx_sh = tx_next_i;
            else                   d.tx_sh = {q.tx_sh[6:0], 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.ss_s    <= 2'b11;
            q.ss_prev <= 1'b1;
            q.tx_sh   <= IDLE_BYTE;
        end else begin
            q <= d;
        end
    end

    // R1
    byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |=> !byte_valid_o);
endmodule

// File: rtl/nfe_store.sv
module nfe_store
    import nfe_pkg::*;
#(
    parameter int MEM_BYTES = 4096,
    localparam int MEM_AW   = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_clear_i,
    input  logic              buf_we_i,
    input  logic [7:0]        buf_idx_i,
    input  logic [7:0]        buf_wdata_i,
    input  logic              wr_en_i,
    input  logic              wr_prog_i,
    input  logic [MEM_AW-1:0] wr_addr_i,
    input  logic [MEM_AW-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o
);
    logic [7:0] mem_q  [MEM_BYTES];
    logic [7:0] pbuf_q [PAGE_BYTES];
    logic [7:0] wr_val;

    assign rd_data_o = mem_q[rd_addr_i];
    assign wr_val    = wr_prog_i ? (mem_q[wr_addr_i] & pbuf_q[wr_addr_i[PAGE_AW-1:0]])
                                 : IDLE_BYTE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= IDLE_BYTE;
        end else if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_BYTES; i++) pbuf_q[i] <= IDLE_BYTE;
        end else if (buf_clear_i) begin
            for (int i = 0; i < PAGE_BYTES; i++) pbuf_q[i] <= IDLE_BYTE;
        end else if (buf_we_i) begin
            pbuf_q[buf_idx_i] <= buf_wdata_i;
        end
    end

    // R7
    prog_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_prog_i) |=>
            ((mem_q[$past(wr_addr_i)] & ~$past(mem_q[wr_addr_i])) == 8'h00));
    // R9
    erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_prog_i) |=> (mem_q[$past(wr_addr_i)] == 8'hFF));
endmodule

// File: rtl/nfe_ctrl.sv
module nfe_ctrl
    import nfe_pkg::*;
#(
    parameter int          MEM_BYTES    = 4096,
    parameter int          PROG_CYCLES  = 300,
    parameter int          ERASE_CYCLES = 5000,
    parameter logic [7:0]  MFR_ID       = 8'hC2,
    parameter logic [15:0] DEV_ID       = 16'h2A17,
    localparam int MEM_AW = $clog2(MEM_BYTES),
    localparam int MAX_CY = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES,
    localparam int CNT_W  = $clog2(MAX_CY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              ss_fall_i,
    input  logic              ss_rise_i,
    input  logic              byte_valid_i,
    input  logic [7:0]        rx_byte_i,
    output logic [7:0]        tx_next_o,
    output logic [MEM_AW-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic              buf_clear_o,
    output logic              buf_we_o,
    output logic [7:0]        buf_idx_o,
    output logic [7:0]        buf_wdata_o,
    output logic              wr_en_o,
    output logic              wr_prog_o,
    output logic [MEM_AW-1:0] wr_addr_o
);
    typedef struct packed {
        phase_t              phase;
        kind_t               kind;
        logic [ADDR_W-1:0]   addr;
        logic [1:0]          idx;
        logic                wel;
        logic                have_data;
        logic [7:0]          ptr;
        job_t                job;
        logic [MEM_AW-1:0]   base;
        logic [WALK_W-1:0]   walk;
        logic [CNT_W-1:0]    cnt;
    } ctrl_t;

    ctrl_t             q, d;
    logic              busy;
    logic [WALK_W-1:0] walk_lim;

    assign busy      = (q.job != JOB_NONE);
    assign walk_lim  = (q.job == JOB_ERASE) ? WALK_W'(SECTOR_BYTES) : WALK_W'(PAGE_BYTES);
    assign rd_addr_o = q.addr[MEM_AW-1:0];
    assign wr_prog_o = (q.job == JOB_PROG);
    assign wr_addr_o = q.base + MEM_AW'(q.walk);

    always_comb begin
        case (q.phase)
            PH_STATUS: tx_next_o = {6'b0, q.wel, busy};
            PH_RDATA:  tx_next_o = rd_data_i;
            PH_IDENT: begin
                case (q.idx)
                    2'd0:    tx_next_o = MFR_ID;
                    2'd1:    tx_next_o = DEV_ID[15:8];
                    2'd2:    tx_next_o = DEV_ID[7:0];
                    default: tx_next_o = IDLE_BYTE;
                endcase
            end
            default:   tx_next_o = IDLE_BYTE;
        endcase
    end

    always_comb begin
        d           = q;
        buf_clear_o = 1'b0;
        buf_we_o    = 1'b0;
        buf_idx_o   = q.ptr;
        buf_wdata_o = rx_byte_i;
        wr_en_o     = 1'b0;

        // commit / erase engine: one array byte per cycle, timer sets the window
        if (busy) begin
            if (q.walk != walk_lim) begin
                wr_en_o = 1'b1;
                d.walk  = q.walk + WALK_W'(1);
            end
            if (q.cnt != '0) begin
                d.cnt = q.cnt - CNT_W'(1);
            end else if (q.walk == walk_lim) begin
                d.job = JOB_NONE;
                d.wel = 1'b0;
            end
        end

        if (ss_rise_i) begin
            if (q.phase == PH_PDATA && q.have_data) begin
                d.job  = JOB_PROG;
                d.base = {q.addr[MEM_AW-1:PAGE_AW], {PAGE_AW{1'b0}}};
                d.walk = '0;
                d.cnt  = CNT_W'(PROG_CYCLES - 1);
            end else if (q.phase == PH_ARMED) begin
                d.job  = JOB_ERASE;
                d.base = {q.addr[MEM_AW-1:SECTOR_AW], {SECTOR_AW{1'b0}}};
                d.walk = '0;
                d.cnt  = CNT_W'(ERASE_CYCLES - 1);
            end
            d.phase = PH_IDLE;
        end else if (ss_fall_i) begin
            d.phase = PH_OPCODE;
        end else if (!sel_i) begin
            d.phase = PH_IDLE;
        end else if (byte_valid_i) begin
            case (q.phase)
                PH_OPCODE: begin
                    d.idx       = '0;
                    d.have_data = 1'b0;
                    if (busy) begin
                        d.phase = (rx_byte_i == CMD_STATUS) ? PH_STATUS : PH_SKIP;
                    end else begin
                        case (rx_byte_i)
                            CMD_WR_ENABLE:  begin d.wel = 1'b1; d.phase = PH_SKIP; end
                            CMD_WR_DISABLE: begin d.wel = 1'b0; d.phase = PH_SKIP; end
                            CMD_STATUS:     d.phase = PH_STATUS;
                            CMD_IDENT:      d.phase = PH_IDENT;
                            CMD_READ: begin
                                d.kind  = K_READ;
                                d.phase = PH_ADDR;
                            end
                            CMD_PROGRAM: begin
                                if (q.wel) begin
                                    d.kind      = K_PROG;
                                    d.phase     = PH_ADDR;
                                    buf_clear_o = 1'b1;
                                end else begin
                                    d.phase = PH_SKIP;
                                end
                            end
                            CMD_ERASE4K: begin
                                d.kind  = K_ERASE;
                                d.phase = q.wel ? PH_ADDR : PH_SKIP;
                            end
                            default: d.phase = PH_SKIP;
                        endcase
                    end
                end
                PH_ADDR: begin
                    d.addr = {q.addr[ADDR_W-9:0], rx_byte_i};
                    d.idx  = q.idx + 2'd1;
                    if (q.idx == 2'd2) begin
                        case (q.kind)
                            K_READ:  d.phase = PH_RDATA;
                            K_PROG: begin
                                d.phase = PH_PDATA;
                                d.ptr   = rx_byte_i;
                            end
                            default: d.phase = PH_ARMED;
                        endcase
                    end
                end
                PH_PDATA: begin
                    buf_we_o    = 1'b1;
                    d.ptr       = q.ptr + 8'd1;
                    d.have_data = 1'b1;
                end
                PH_RDATA: d.addr = q.addr + ADDR_W'(1);
                PH_IDENT: d.idx = (q.idx == 2'd3) ? 2'd3 : q.idx + 2'd1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
            q.kind  <= K_READ;
            q.job   <= JOB_NONE;
        end else begin
            q <= d;
        end
    end

    // R5
    job_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(q.wel));
    // R10
    done_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !q.wel);
    // R11
    no_stage_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we_o |-> !busy);
    // R9
    write_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> busy);
    // R12
    empty_prog_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_rise_i && q.phase == PH_PDATA && !q.have_data) |=> !busy);
endmodule

// File: rtl/nor_flash_emu.sv
module nor_flash_emu
    import nfe_pkg::*;
#(
    parameter int          MEM_BYTES    = 4096,
    parameter int          PROG_CYCLES  = 300,
    parameter int          ERASE_CYCLES = 5000,
    parameter logic [7:0]  MFR_ID       = 8'hC2,
    parameter logic [15:0] DEV_ID       = 16'h2A17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_ss_n,
    input  logic spi_sck,
    input  logic spi_mosi,
    output wire  spi_miso
);
    localparam int MEM_AW = $clog2(MEM_BYTES);

    logic              sel, ss_fall, ss_rise, byte_valid, tx_bit;
    logic [7:0]        rx_byte, tx_next, rd_data, buf_idx, buf_wdata;
    logic              buf_clear, buf_we, wr_en, wr_prog;
    logic [MEM_AW-1:0] rd_addr, wr_addr;

    assign spi_miso = spi_ss_n ? 1'bz : tx_bit;

    nfe_spi_link u_link (
        .clk(clk), .rst_n(rst_n),
        .ss_n_i(spi_ss_n), .sck_i(spi_sck), .mosi_i(spi_mosi),
        .tx_next_i(tx_next),
        .sel_o(sel), .ss_fall_o(ss_fall), .ss_rise_o(ss_rise),
        .byte_valid_o(byte_valid), .rx_byte_o(rx_byte), .tx_bit_o(tx_bit)
    );

    nfe_ctrl #(
        .MEM_BYTES(MEM_BYTES), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES),
        .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .sel_i(sel), .ss_fall_i(ss_fall), .ss_rise_i(ss_rise),
        .byte_valid_i(byte_valid), .rx_byte_i(rx_byte),
        .tx_next_o(tx_next), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .buf_clear_o(buf_clear), .buf_we_o(buf_we), .buf_idx_o(buf_idx),
        .buf_wdata_o(buf_wdata), .wr_en_o(wr_en), .wr_prog_o(wr_prog),
        .wr_addr_o(wr_addr)
    );

    nfe_store #(.MEM_BYTES(MEM_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .buf_clear_i(buf_clear), .buf_we_i(buf_we), .buf_idx_i(buf_idx),
        .buf_wdata_i(buf_wdata), .wr_en_i(wr_en), .wr_prog_i(wr_prog),
        .wr_addr_i(wr_addr), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );
endmodule

// File: tb/nor_flash_emu_bench.sv
`timescale 1ns/1ps
module nor_flash_emu_bench;
    localparam int HALF = 8;
    localparam logic [7:0]  B_MFR = 8'hC2;
    localparam logic [15:0] B_DEV = 16'h2A17;
    // {addr[23:0], program byte, expected read-back}
    localparam logic [39:0] VEC [5] = '{
        {24'h000010, 8'hA5, 8'hA5},
        {24'h000011, 8'h5A, 8'h5A},
        {24'h000010, 8'h0F, 8'h05},
        {24'h001020, 8'h00, 8'h00},
        {24'h0001FF, 8'h81, 8'h81}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0, ss_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    wire  miso;
    int   errs = 0, checks = 0;
    logic [7:0] r0, r1, r2, r3;

    nor_flash_emu #(
        .MEM_BYTES(8192), .PROG_CYCLES(300), .ERASE_CYCLES(5000),
        .MFR_ID(B_MFR), .DEV_ID(B_DEV)
    ) u_nor_flash_emu (
        .clk(clk), .rst_n(rst_n), .spi_ss_n(ss_n), .spi_sck(sck),
        .spi_mosi(mosi), .spi_miso(miso)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            tick(HALF);
            rx[i] = miso;
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        bits(tx, 8, rx);
    endtask

    task automatic sel_on();
        ss_n = 1'b0;
        tick(HALF);
    endtask

    task automatic sel_off();
        tick(HALF);
        ss_n = 1'b1;
        tick(2 * HALF);
    endtask

    task automatic send_addr(input logic [23:0] a);
        logic [7:0] dmy;
        xfer(a[23:16], dmy);
        xfer(a[15:8], dmy);
        xfer(a[7:0], dmy);
    endtask

    task automatic cmd_only(input logic [7:0] op);
        logic [7:0] dmy;
        sel_on();
        xfer(op, dmy);
        sel_off();
    endtask

    task automatic get_status(output logic [7:0] st);
        logic [7:0] dmy;
        sel_on();
        xfer(8'h05, dmy);
        xfer(8'hFF, st);
        sel_off();
    endtask

    task automatic wait_idle();
        logic [7:0] st;
        do get_status(st); while (st[0] === 1'b1);
    endtask

    task automatic read1(input logic [23:0] a, output logic [7:0] v);
        logic [7:0] dmy;
        sel_on();
        xfer(8'h03, dmy);
        send_addr(a);
        xfer(8'hFF, v);
        sel_off();
    endtask

    task automatic prog1(input logic [23:0] a, input logic [7:0] v);
        logic [7:0] dmy;
        sel_on();
        xfer(8'h02, dmy);
        send_addr(a);
        xfer(v, dmy);
        sel_off();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        errs++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] dmy;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1: deselected output floats
        checks++;
        if (miso !== 1'bz) begin
            errs++;
            $display("FAIL R1: actual %b expected z", miso);
        end
        get_status(r0);
        chk("R4 status after reset", r0, 8'h00);
        read1(24'h000000, r0);
        chk("R13 blank array", r0, 8'hFF);

        // R2: identification order
        sel_on();
        xfer(8'h9F, dmy);
        xfer(8'hFF, r0);
        xfer(8'hFF, r1);
        xfer(8'hFF, r2);
        sel_off();
        chk("R2 manufacturer", r0, B_MFR);
        chk("R2 device hi", r1, B_DEV[15:8]);
        chk("R2 device lo", r2, B_DEV[7:0]);

        // R3 / R4: status repeats, WEL set and cleared
        cmd_only(8'h06);
        sel_on();
        xfer(8'h05, dmy);
        xfer(8'hFF, r0);
        xfer(8'hFF, r1);
        sel_off();
        chk("R4 WEL set", r0, 8'h02);
        chk("R3 status repeated", r1, 8'h02);
        cmd_only(8'h04);
        get_status(r0);
        chk("R4 WEL cleared", r0, 8'h00);

        // R5: program without WEL ignored
        prog1(24'h000400, 8'h00);
        get_status(r0);
        chk("R5 no busy without WEL", r0, 8'h00);
        read1(24'h000400, r0);
        chk("R5 array unchanged", r0, 8'hFF);

        // R7 / R10: vector table walk
        foreach (VEC[k]) begin
            cmd_only(8'h06);
            prog1(VEC[k][39:16], VEC[k][15:8]);
            if (k == 0) begin
                get_status(r0);
                chk("R10 busy with WEL during program", r0, 8'h03);
            end
            wait_idle();
            if (k == 0) begin
                get_status(r0);
                chk("R10 WEL cleared at end", r0, 8'h00);
            end
            read1(VEC[k][39:16], r0);
            chk("R7 AND programming", r0, VEC[k][7:0]);
        end

        // R8 / R6: wrap inside page; read runs across page
        cmd_only(8'h06);
        sel_on();
        xfer(8'h02, dmy);
        send_addr(24'h0002FE);
        xfer(8'h11, dmy);
        xfer(8'h22, dmy);
        xfer(8'h33, dmy);
        sel_off();
        wait_idle();
        sel_on();
        xfer(8'h03, dmy);
        send_addr(24'h0002FE);
        xfer(8'hFF, r0);
        xfer(8'hFF, r1);
        xfer(8'hFF, r2);
        xfer(8'hFF, r3);
        sel_off();
        chk("R8 byte FE", r0, 8'h11);
        chk("R8 byte FF", r1, 8'h22);
        chk("R6 next page untouched", r2, 8'hFF);
        chk("R6 read continues", r3, 8'hFF);
        read1(24'h000200, r0);
        chk("R8 wrapped to page start", r0, 8'h33);
        get_status(r0);
        chk("R6 read sets no busy", r0, 8'h00);

        // R12: truncated program and partial opcode
        cmd_only(8'h06);
        sel_on();
        xfer(8'h02, dmy);
        send_addr(24'h000500);
        bits(8'h00, 4, dmy);
        sel_off();
        get_status(r0);
        chk("R12 truncated program no busy", r0, 8'h02);
        read1(24'h000500, r0);
        chk("R12 nothing committed", r0, 8'hFF);
        sel_on();
        bits(8'h9F, 4, dmy);
        sel_off();
        get_status(r0);
        chk("R12 partial byte discarded", r0, 8'h02);

        // R9 / R11: erase sector 0, commands dropped while busy
        sel_on();
        xfer(8'h20, dmy);
        send_addr(24'h000123);
        sel_off();
        read1(24'h001020, r0);
        chk("R11 read ignored while busy", r0, 8'hFF);
        get_status(r0);
        chk("R3 status accepted while busy", r0, 8'h03);
        wait_idle();
        read1(24'h000010, r0);
        chk("R9 sector erased", r0, 8'hFF);
        read1(24'h0002FE, r0);
        chk("R9 sector erased far byte", r0, 8'hFF);
        read1(24'h001020, r0);
        chk("R9 other sector kept", r0, 8'h00);
        get_status(r0);
        chk("R10 WEL cleared after erase", r0, 8'h00);

        // R5: erase without WEL
        sel_on();
        xfer(8'h20, dmy);
        send_addr(24'h001000);
        sel_off();
        get_status(r0);
        chk("R5 erase without WEL no busy", r0, 8'h00);
        read1(24'h001020, r0);
        chk("R5 sector kept", r0, 8'h00);

        finish_run();
    end
endmodule